// File: doc/BRIEF.md
# Six-State Skip-Code Counter

This block is a synchronous 3-bit counter that walks a fixed, non-binary loop of six codes: 000, 001, 010, 100, 101, 110, then back to 000. Codes 011 and 111 never occur in normal counting. The state lives in three JK flip-flops. A small excitation network drives each J and K input from the present state. No adder or next-state lookup is used.

The block is used as a short sequencer or as a divide-by-six tick source. A count enable advances the loop by one step on each rising clock edge where the enable is high. A synchronous reset returns the loop to 000. A terminal flag marks the last code of the loop, so a neighbour can take one pulse per revolution. The pins are plain control and status pins with no stream handshake, because no data moves through the block.

If an upset ever leaves the register on one of the two unused codes, the next enabled clock brings it back to 000. The counter therefore cannot stay stuck outside the loop.

Top module: `seq6_jk_counter`

## Requirements
- R1: When `rst` is high at a rising edge of `clk`, `state_o` becomes 000 after that edge, whatever `cnt_en` is.
- R2: When `rst` is low and `cnt_en` is low at a rising edge, `state_o` keeps its value across that edge.
- R3: When `rst` is low and `cnt_en` is high, each rising edge moves `state_o` one step along 000 to 001, 001 to 010, 010 to 100, 100 to 101 and 101 to 110. Bit 2 is the most significant flip-flop.
- R4: From 110, an enabled edge returns `state_o` to 000.
- R5: From either unused code, 011 or 111, one enabled edge leads to 000.
- R6: `term_o` is 1 exactly while `state_o` equals 110, and 0 for every other code.
- R7: Each storage cell behaves as a JK flip-flop on the rising edge. J=0,K=0 holds. J=0,K=1 gives 0. J=1,K=0 gives 1. J=1,K=1 inverts the stored bit. A high synchronous clear forces 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to 000 |
| cnt_en | input | 1 | Advance the loop on this edge when high |
| state_o | output | 3 | Present code; bit 2 = A, bit 1 = B, bit 0 = C |
| term_o | output | 1 | High while the code is 110 |

## Verification
A wrong excitation term or a faulty cell shows up at `state_o` on the very next enabled edge. It appears either as a skipped or repeated code, or as entry into 011 or 111. The fault also shifts the position of the `term_o` pulse within the six-edge loop. The bench compares both outputs with a behavioural model after every edge, so any divergence is reported within one clock. The two unused codes are entered on purpose, to confirm that recovery takes exactly one enabled edge. A stand-alone cell is driven through all four J/K combinations.

// File: rtl/seq6_pkg.sv
package seq6_pkg;
  localparam int unsigned CNT_W = 3;
  typedef logic [CNT_W-1:0] cnt_t;

  // bit positions of the three flip-flops
  localparam int unsigned IDX_A = 2;
  localparam int unsigned IDX_B = 1;
  localparam int unsigned IDX_C = 0;

  localparam cnt_t CODE_ZERO = 3'b000;
  localparam cnt_t CODE_ONE  = 3'b001;
  localparam cnt_t CODE_TWO  = 3'b010;
  localparam cnt_t CODE_BAD3 = 3'b011;
  localparam cnt_t CODE_FOUR = 3'b100;
  localparam cnt_t CODE_FIVE = 3'b101;
  localparam cnt_t CODE_TERM = 3'b110;
  localparam cnt_t CODE_BAD7 = 3'b111;
endpackage

// File: rtl/jk_cell.sv
module jk_cell (
  input  logic clk,
  input  logic rst,
  input  logic j_i,
  input  logic k_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_o <= 1'b0;
    end else begin
      unique case ({j_i, k_i})
        2'b00: q_o <= q_o;
        2'b01: q_o <= 1'b0;
        2'b10: q_o <= 1'b1;
        2'b11: q_o <= ~q_o;
        default: q_o <= q_o;
      endcase
    end
  end

  // R7
  jk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!j_i && !k_i) |=> $stable(q_o));
  // R7
  jk_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!j_i && k_i) |=> !q_o);
  // R7
  jk_set_chk: assert property (@(posedge clk) disable iff (rst)
    (j_i && !k_i) |=> q_o);
  // R7
  jk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (j_i && k_i) |=> (q_o != $past(q_o)));
endmodule

// File: rtl/seq6_excite.sv
module seq6_excite
  import seq6_pkg::*;
(
  input  logic en_i,
  input  cnt_t q_i,
  output cnt_t j_o,
  output cnt_t k_o
);
  logic qa, qb, qc;
  assign qa = q_i[IDX_A];
  assign qb = q_i[IDX_B];
  assign qc = q_i[IDX_C];

  // Reduced terms from the present-to-next transition table,
  // with 011 and 111 steered to 000.
  always_comb begin
    j_o = '0;
    k_o = '0;
    if (en_i) begin
      j_o[IDX_A] = qb & ~qc;
      k_o[IDX_A] = qb;
      j_o[IDX_B] = qc;
      k_o[IDX_B] = 1'b1;
      j_o[IDX_C] = ~qb;
      k_o[IDX_C] = 1'b1;
    end
  end

  logic unused_qa;
  assign unused_qa = qa;
endmodule

// File: rtl/seq6_jk_counter.sv
module seq6_jk_counter
  import seq6_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  output logic [CNT_W-1:0] state_o,
  output logic             term_o
);
  cnt_t q_vec, j_vec, k_vec;

  seq6_excite u_excite (
    .en_i (cnt_en),
    .q_i  (q_vec),
    .j_o  (j_vec),
    .k_o  (k_vec)
  );

  for (genvar gi = 0; gi < CNT_W; gi++) begin : g_bit
    jk_cell u_cell (
      .clk (clk),
      .rst (rst),
      .j_i (j_vec[gi]),
      .k_i (k_vec[gi]),
      .q_o (q_vec[gi])
    );
  end

  assign state_o = q_vec;
  assign term_o  = (q_vec == CODE_TERM);

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(state_o));
  // R3
  skip_three_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && state_o == CODE_TWO) |=> (state_o == CODE_FOUR));
  // R3
  step_from_five_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && state_o == CODE_FIVE) |=> (state_o == CODE_TERM));
  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && term_o) |=> (state_o == CODE_ZERO));
  // R5
  unused_recover_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && (state_o == CODE_BAD3 || state_o == CODE_BAD7))
      |=> (state_o == CODE_ZERO));
endmodule

// File: tb/test_seq6_jk_counter.sv
`timescale 1ns/1ps
module test_seq6_jk_counter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_en = 1'b0;
  logic [2:0] state_o;
  logic term_o;
  logic cj = 1'b0, ck = 1'b0, cq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int pat = 0;

  int m_state = 0;
  int m_q = 0;

  always #5 clk = ~clk;

  seq6_jk_counter i_seq6_jk_counter (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .state_o(state_o), .term_o(term_o)
  );

  jk_cell u_cell_dut (.clk(clk), .rst(rst), .j_i(cj), .k_i(ck), .q_o(cq));

  function automatic int nxt(input int s);
    case (s)
      0: return 1;
      1: return 2;
      2: return 4;
      4: return 5;
      5: return 6;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_state <= 0;
      m_q <= 0;
    end else begin
      if (cnt_en) m_state <= nxt(m_state);
      if (cj && ck) m_q <= 1 - m_q;
      else if (cj) m_q <= 1;
      else if (ck) m_q <= 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmp(input string req);
    check(int'(state_o) == m_state, req, int'(state_o), m_state);
    check(int'(term_o) == int'(m_state == 6), "R6", int'(term_o), int'(m_state == 6));
    check(int'(cq) == m_q, "R7", int'(cq), m_q);
  endtask

  task automatic run(input int n, input logic r, input logic e, input string req);
    for (int i = 0; i < n; i++) begin
      rst = r;
      cnt_en = e;
      cj = pat[0];
      ck = pat[1];
      pat++;
      @(posedge clk);
      @(negedge clk);
      cmp(req);
    end
  endtask

  task automatic inject(input logic [2:0] code);
    rst = 0;
    cnt_en = 1;
    force i_seq6_jk_counter.g_bit[0].u_cell.q_o = code[0];
    force i_seq6_jk_counter.g_bit[1].u_cell.q_o = code[1];
    force i_seq6_jk_counter.g_bit[2].u_cell.q_o = code[2];
    #1;
    release i_seq6_jk_counter.g_bit[0].u_cell.q_o;
    release i_seq6_jk_counter.g_bit[1].u_cell.q_o;
    release i_seq6_jk_counter.g_bit[2].u_cell.q_o;
    m_state = int'(code);
    @(posedge clk);
    @(negedge clk);
    cmp("R5");
  endtask

  initial begin
    @(posedge clk);
    @(negedge clk);
    cmp("R1");
    run(2, 1, 1, "R1");            // reset wins over enable
    run(6, 0, 1, "R3");            // full loop
    run(3, 0, 1, "R4");            // wrap and beyond
    run(4, 0, 0, "R2");            // idle hold
    run(2, 0, 1, "R3");
    run(3, 0, 0, "R2");
    run(1, 1, 1, "R1");            // reset mid-count
    inject(3'b011);
    run(1, 1, 0, "R1");
    inject(3'b111);
    run(14, 0, 1, "R4");
    run(8, 0, 0, "R7");            // cell patterns with counter idle
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule